// File: doc/BRIEF.md
# Data Cache Tag Entry Auditor

This block audits one way entry read from a data cache tag array. It takes the tag-high word (coherence state and replacement ordering) and the physical tag word, plus the set index the entry was read from. It reports whether the stored coherence state is one of the permitted encodings. For a permitted state it also reports whether either of the two parity bits that protect the physical tag disagrees with its region. Error-handling firmware or a debug engine feeds entries one at a time and reads the verdict one clock later.

Alongside the verdict the block returns a compact class code for the state, the full physical address of the line, and the replacement ordering split into four way numbers. The two verdict flags are also placed into a 32-bit error word at the bit positions that the surrounding error-status logic expects.

Top module: `dtag_audit`

## Requirements
- R1: Every input strobe `in_valid` produces exactly one `out_valid` pulse one clock later. All results belong to the entry that was presented with that strobe. Without a strobe, `out_valid` is low on the next clock.
- R2: While `rst` is high at a clock edge, every output goes to zero on that edge.
- R3: The state field is tag-high bits 29..25. Six values are legal, and each maps to a class code: 0x00 gives 0 (invalid), 0x0F gives 1 (shared), 0x13 gives 2 (non-coherent exclusive clean), 0x19 gives 3 (non-coherent exclusive dirty), 0x16 gives 4 (coherent exclusive clean) and 0x1C gives 5 (coherent exclusive dirty). A legal state clears `state_err`.
- R4: Each of the other 26 state values sets `state_err` and gives class code 7. It always clears `addr_err`, whatever the tag parity.
- R5: For a legal state, `addr_err` is set when physical-tag bit 11 differs from the XOR of tag bits 39..26.
- R6: For a legal state, `addr_err` is set when physical-tag bit 10 differs from the XOR of tag bits 25..13. A tag bit outside both regions and both parity bits (bits 9..0 and 12) never affects `addr_err`.
- R7: `phys_addr` is tag bits 39..13 above the 13-bit set index.
- R8: The LRU field is tag-high bits 21..14. `lru_list` slot k (bits 2k+1..2k) holds the k-th way number, from least recent (slot 0) to most recent (slot 3). `lru_victim` equals slot 0 and `lru_newest` equals slot 3.
- R9: `err_word` has bit 30 equal to `state_err` and bit 29 equal to `addr_err`. All of its other bits are zero.
- R10: When no strobe is given, every result output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Entry presented this cycle |
| tag_hi | input | 32 | Tag-high word (state and LRU fields) |
| ptag | input | 40 | Physical tag word with parity bits |
| set_index | input | 13 | Set index the entry was read from |
| out_valid | output | 1 | Results valid this cycle |
| state_err | output | 1 | State encoding is not permitted |
| addr_err | output | 1 | Physical tag parity mismatch |
| state_class | output | 3 | Class code of the state |
| phys_addr | output | 40 | Reconstructed physical line address |
| lru_list | output | 8 | Four 2-bit way numbers, least recent in slot 0 |
| lru_victim | output | 2 | Least recently used way |
| lru_newest | output | 2 | Most recently used way |
| err_word | output | 32 | Error flags at status bit positions |

## Verification
All results come from a single register stage. They are due on the clock edge that follows the strobed edge, together with `out_valid`. The bench drives each entry on a falling edge, drops the strobe on the next falling edge and reads every output there, half a period after the capturing edge. Hold checks change the inputs without a strobe and compare the outputs one falling edge later against the values previously read.

// File: rtl/dtag_audit_pkg.sv
package dtag_audit_pkg;

  localparam int STATE_W = 5;

  typedef enum logic [2:0] {
    CLS_INVALID   = 3'd0,
    CLS_SHARED    = 3'd1,
    CLS_NCX_CLEAN = 3'd2,
    CLS_NCX_DIRTY = 3'd3,
    CLS_CX_CLEAN  = 3'd4,
    CLS_CX_DIRTY  = 3'd5,
    CLS_ILLEGAL   = 3'd7
  } state_cls_e;

  localparam logic [STATE_W-1:0] ST_INVALID   = 5'h00;
  localparam logic [STATE_W-1:0] ST_SHARED    = 5'h0F;
  localparam logic [STATE_W-1:0] ST_NCX_CLEAN = 5'h13;
  localparam logic [STATE_W-1:0] ST_NCX_DIRTY = 5'h19;
  localparam logic [STATE_W-1:0] ST_CX_CLEAN  = 5'h16;
  localparam logic [STATE_W-1:0] ST_CX_DIRTY  = 5'h1C;

endpackage

// File: rtl/dtag_state_decode.sv
module dtag_state_decode
  import dtag_audit_pkg::*;
(
  input  logic [STATE_W-1:0] code,
  output state_cls_e         cls,
  output logic               legal
);
  always_comb begin
    legal = 1'b1;
    unique case (code)
      ST_INVALID:   cls = CLS_INVALID;
      ST_SHARED:    cls = CLS_SHARED;
      ST_NCX_CLEAN: cls = CLS_NCX_CLEAN;
      ST_NCX_DIRTY: cls = CLS_NCX_DIRTY;
      ST_CX_CLEAN:  cls = CLS_CX_CLEAN;
      ST_CX_DIRTY:  cls = CLS_CX_DIRTY;
      default: begin
        cls   = CLS_ILLEGAL;
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dtag_region_parity.sv
module dtag_region_parity #(
  parameter int W    = 40,
  parameter int MSB  = 39,
  parameter int LSB  = 26,
  parameter int PBIT = 11
) (
  input  logic [W-1:0] word,
  output logic         bad
);
  localparam int RW = MSB - LSB + 1;

  logic [RW-1:0] region;

  always_comb begin
    region = word[MSB:LSB];
    bad    = word[PBIT] ^ (^region);
  end
endmodule

// File: rtl/dtag_lru_unpack.sv
module dtag_lru_unpack #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS*WAY_W-1:0] field,
  output logic [WAYS*WAY_W-1:0] slots,
  output logic [WAY_W-1:0]      oldest,
  output logic [WAY_W-1:0]      newest
);
  for (genvar k = 0; k < WAYS; k++) begin : g_slot
    assign slots[k*WAY_W +: WAY_W] = field[k*WAY_W +: WAY_W];
  end

  assign oldest = field[0 +: WAY_W];
  assign newest = field[(WAYS-1)*WAY_W +: WAY_W];
endmodule

// File: rtl/dtag_audit.sv
module dtag_audit
  import dtag_audit_pkg::*;
#(
  parameter int TAGHI_W   = 32,
  parameter int PTAG_W    = 40,
  parameter int IDX_W     = 13,
  parameter int ST_LSB    = 25,
  parameter int LRU_LSB   = 14,
  parameter int WAYS      = 4,
  parameter int PAR_HI_LSB = 26,
  parameter int PBIT_HI   = 11,
  parameter int PBIT_LO   = 10,
  parameter int ERR_ST_BIT = 30,
  parameter int ERR_AD_BIT = 29
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [TAGHI_W-1:0]      tag_hi,
  input  logic [PTAG_W-1:0]       ptag,
  input  logic [IDX_W-1:0]        set_index,
  output logic                    out_valid,
  output logic                    state_err,
  output logic                    addr_err,
  output logic [2:0]              state_class,
  output logic [PTAG_W-1:0]       phys_addr,
  output logic [WAYS*$clog2(WAYS)-1:0] lru_list,
  output logic [$clog2(WAYS)-1:0] lru_victim,
  output logic [$clog2(WAYS)-1:0] lru_newest,
  output logic [TAGHI_W-1:0]      err_word
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int LRU_W = WAYS * WAY_W;
  localparam int PAR_LO_LSB = IDX_W;
  localparam int NREG = 2;

  // combinational audit of the presented entry
  state_cls_e        cls_c;
  logic              legal_c;
  logic [NREG-1:0]   par_bad;
  logic [LRU_W-1:0]  slots_c;
  logic [WAY_W-1:0]  oldest_c, newest_c;
  logic [PTAG_W-1:0] pa_c;
  logic [TAGHI_W-1:0] ew_c;
  logic              aerr_c;

  dtag_state_decode u_state (
    .code  (tag_hi[ST_LSB +: STATE_W]),
    .cls   (cls_c),
    .legal (legal_c)
  );

  // region 0: upper tag bits, region 1: lower tag bits
  for (genvar r = 0; r < NREG; r++) begin : g_par
    localparam int MSB_R  = (r == 0) ? PTAG_W - 1  : PAR_HI_LSB - 1;
    localparam int LSB_R  = (r == 0) ? PAR_HI_LSB  : PAR_LO_LSB;
    localparam int PBIT_R = (r == 0) ? PBIT_HI     : PBIT_LO;
    dtag_region_parity #(
      .W(PTAG_W), .MSB(MSB_R), .LSB(LSB_R), .PBIT(PBIT_R)
    ) u_par (
      .word (ptag),
      .bad  (par_bad[r])
    );
  end

  dtag_lru_unpack #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
    .field  (tag_hi[LRU_LSB +: LRU_W]),
    .slots  (slots_c),
    .oldest (oldest_c),
    .newest (newest_c)
  );

  always_comb begin
    aerr_c = legal_c & (|par_bad);
    pa_c   = {ptag[PTAG_W-1:IDX_W], set_index};
    ew_c   = '0;
    ew_c[ERR_ST_BIT] = ~legal_c;
    ew_c[ERR_AD_BIT] = aerr_c;
  end

  // single output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      state_err   <= 1'b0;
      addr_err    <= 1'b0;
      state_class <= '0;
      phys_addr   <= '0;
      lru_list    <= '0;
      lru_victim  <= '0;
      lru_newest  <= '0;
      err_word    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        state_err   <= ~legal_c;
        addr_err    <= aerr_c;
        state_class <= cls_c;
        phys_addr   <= pa_c;
        lru_list    <= slots_c;
        lru_victim  <= oldest_c;
        lru_newest  <= newest_c;
        err_word    <= ew_c;
      end
    end
  end
endmodule

// File: rtl/dtag_audit_chk.sv
module dtag_audit_chk #(
  parameter int TAGHI_W    = 32,
  parameter int PTAG_W     = 40,
  parameter int IDX_W      = 13,
  parameter int ST_LSB     = 25,
  parameter int WAYS       = 4,
  parameter int ERR_ST_BIT = 30,
  parameter int ERR_AD_BIT = 29
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [TAGHI_W-1:0]      tag_hi,
  input logic [PTAG_W-1:0]       ptag,
  input logic [IDX_W-1:0]        set_index,
  input logic                    out_valid,
  input logic                    state_err,
  input logic                    addr_err,
  input logic [2:0]              state_class,
  input logic [PTAG_W-1:0]       phys_addr,
  input logic [WAYS*$clog2(WAYS)-1:0] lru_list,
  input logic [$clog2(WAYS)-1:0] lru_victim,
  input logic [$clog2(WAYS)-1:0] lru_newest,
  input logic [TAGHI_W-1:0]      err_word
);
  logic [4:0] code_in;
  logic       ok_in;
  assign code_in = tag_hi[ST_LSB +: 5];
  assign ok_in = (code_in == 5'h00) || (code_in == 5'h0F) || (code_in == 5'h13) ||
                 (code_in == 5'h19) || (code_in == 5'h16) || (code_in == 5'h1C);

  assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (!out_valid && err_word == '0 && phys_addr == '0 && !state_err));
  assert_bad_state_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ok_in) |=> (state_err && !addr_err && state_class == 3'd7));
  assert_good_state_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ok_in) |=> (!state_err && state_class != 3'd7));
  assert_index_low_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (phys_addr[IDX_W-1:0] == $past(set_index)));
  assert_err_word_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (err_word[ERR_ST_BIT] == state_err && err_word[ERR_AD_BIT] == addr_err &&
                   $countones(err_word) == (32'(state_err) + 32'(addr_err))));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(phys_addr) && $stable(err_word) && $stable(lru_list) &&
                   $stable(state_class)));
endmodule

bind dtag_audit dtag_audit_chk #(
  .TAGHI_W(TAGHI_W), .PTAG_W(PTAG_W), .IDX_W(IDX_W), .ST_LSB(ST_LSB),
  .WAYS(WAYS), .ERR_ST_BIT(ERR_ST_BIT), .ERR_AD_BIT(ERR_AD_BIT)
) chk_i (.*);

// File: tb/dtag_audit_tb_top.sv
`timescale 1ns/1ps
module dtag_audit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] tag_hi;
  logic [39:0] ptag;
  logic [12:0] set_index;
  logic        out_valid, state_err, addr_err;
  logic [2:0]  state_class;
  logic [39:0] phys_addr;
  logic [7:0]  lru_list;
  logic [1:0]  lru_victim, lru_newest;
  logic [31:0] err_word;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dtag_audit dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] fix_par(input logic [39:0] p);
    logic [39:0] q = p;
    q[11] = ^p[39:26];
    q[10] = ^p[25:13];
    return q;
  endfunction

  function automatic logic [2:0] exp_cls(input logic [4:0] s);
    case (s)
      5'h00: return 3'd0;
      5'h0F: return 3'd1;
      5'h13: return 3'd2;
      5'h19: return 3'd3;
      5'h16: return 3'd4;
      5'h1C: return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  task automatic apply(input logic [31:0] th, input logic [39:0] pt, input logic [12:0] ix);
    logic [4:0] s = th[29:25];
    logic legal = (exp_cls(s) != 3'd7);
    logic hi_bad = pt[11] ^ (^pt[39:26]);
    logic lo_bad = pt[10] ^ (^pt[25:13]);
    logic ae = legal && (hi_bad || lo_bad);
    logic [31:0] ew = 32'(!legal) << 30 | 32'(ae) << 29;
    @(negedge clk);
    tag_hi = th; ptag = pt; set_index = ix; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 out_valid", 64'(out_valid), 64'd1);
    chk(legal ? "R3 state_err" : "R4 state_err", 64'(state_err), 64'(!legal));
    chk(legal ? "R3 class" : "R4 class", 64'(state_class), 64'(exp_cls(s)));
    chk(hi_bad ? "R5 addr_err" : "R6 addr_err", 64'(addr_err), 64'(ae));
    chk("R7 phys_addr", 64'(phys_addr), 64'({pt[39:13], ix}));
    chk("R8 lru_list", 64'(lru_list), 64'((th >> 14) & 32'hFF));
    chk("R8 victim", 64'(lru_victim), 64'((th >> 14) & 32'h3));
    chk("R8 newest", 64'(lru_newest), 64'((th >> 20) & 32'h3));
    chk("R9 err_word", 64'(err_word), 64'(ew));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; tag_hi = '1; ptag = '1; set_index = '1;
    repeat (3) @(negedge clk);
    chk("R2 reset out_valid", 64'(out_valid), 64'd0);
    chk("R2 reset err_word", 64'(err_word), 64'd0);
    chk("R2 reset phys_addr", 64'(phys_addr), 64'd0);
    chk("R2 reset lru_list", 64'(lru_list), 64'd0);
    rst = 1'b0;

    // R3/R4/R5/R6: all state codes, clean tag and a flip in each region
    for (int s = 0; s < 32; s++) begin
      logic [31:0] th = $urandom;
      logic [39:0] pt = fix_par({$urandom, $urandom});
      th[29:25] = 5'(s);
      apply(th, pt, 13'($urandom));
      apply(th, pt ^ (40'd1 << (26 + s % 14)), 13'($urandom));
      apply(th, pt ^ (40'd1 << (13 + s % 13)), 13'($urandom));
    end

    // R5/R6: every single-bit flip for two legal states
    for (int st = 0; st < 2; st++) begin
      for (int b = 0; b < 40; b++) begin
        logic [31:0] th = $urandom;
        logic [39:0] pt = fix_par({$urandom, $urandom});
        th[29:25] = (st == 0) ? 5'h1C : 5'h00;
        apply(th, pt ^ (40'd1 << b), 13'(b * 97));
      end
    end

    // R10: inputs change without strobe, outputs hold; R1 no pulse
    for (int h = 0; h < 8; h++) begin
      logic [39:0] pa0;
      logic [31:0] ew0;
      logic [7:0]  l0;
      logic [2:0]  c0;
      logic [31:0] th = $urandom;
      th[29:25] = 5'(h * 5);
      apply(th, {$urandom, $urandom}, 13'($urandom));
      pa0 = phys_addr; ew0 = err_word; l0 = lru_list; c0 = state_class;
      tag_hi = ~tag_hi; ptag = ~ptag; set_index = ~set_index;
      @(negedge clk);
      chk("R1 no pulse", 64'(out_valid), 64'd0);
      chk("R10 hold phys_addr", 64'(phys_addr), 64'(pa0));
      chk("R10 hold err_word", 64'(err_word), 64'(ew0));
      chk("R10 hold lru", 64'(lru_list), 64'(l0));
      chk("R10 hold class", 64'(state_class), 64'(c0));
    end

    // R2: reset in mid-run clears results
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R2 mid reset err_word", 64'(err_word), 64'd0);
    chk("R2 mid reset phys_addr", 64'(phys_addr), 64'd0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule